// File: doc/BRIEF.md
# LIN Header Transmit Sequencer

This block drives the serial line in front of a UART transmitter and, when the port is acting as bus host, produces the header of a LIN frame by itself. Software or a bus-side controller writes one byte together with a two-bit command. That command is used for this one write only; it is not stored for later writes and it is not kept for reading back.

The command picks one of three behaviours:
- **Plain transmission.** The byte goes out as an ordinary 8N1 character.
- **Break only.** A long dominant break field goes out, followed by a recessive delimiter.
- **Automatic header.** The break and delimiter go out, then the 0x55 sync character, then the written byte as the protected identifier.

All bit timing comes from a one-cycle `bit_tick` pulse, issued once per bit period by an external baud generator. Each bit is put on the line when the previous period ends, and it is held until the next tick.

The sequencer has six named states:
- `ST_IDLE`: the line is recessive.
- `ST_BREAK`: the line is dominant.
- `ST_DELIM`: the line is recessive.
- `ST_SYNC`, `ST_IDENT` and `ST_DATA`: the line is driven by a shared 10-bit frame shifter.

Its transitions are as follows:
- `ST_IDLE` goes to `ST_DATA` on an accepted plain write.
- `ST_IDLE` goes to `ST_BREAK` on an accepted header write.
- `ST_BREAK` goes to `ST_DELIM` after `BREAK_BITS` ticks.
- `ST_DELIM` goes to `ST_SYNC` (automatic mode) or to `ST_IDLE` (break only) after `DELIM_BITS` ticks.
- `ST_SYNC` goes to `ST_IDENT` at its last stop bit.
- `ST_IDENT` and `ST_DATA` go back to `ST_IDLE` at their last stop bit.

Top module: `lin_hdr_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `txd` is 1 and `busy` is 0.
- R2: A write accepted with command code 0 sends one frame: a start bit 0, then the 8 data bits LSB first, then a stop bit 1.
- R3: In host mode, command code 1 sends 13 bit periods of 0 followed by 1 bit period of 1, and nothing else.
- R4: In host mode, command code 2 sends 13 zeros, then one 1, then a frame carrying 0x55, then a frame carrying the written byte. Both frames have the format given in R2.
- R5: When `host_mode` is 0, command codes 1 and 2 behave as code 0.
- R6: The unused command code 3 behaves as code 0.
- R7: `busy` rises in the cycle after an accepted write. It falls only at the tick that ends the last bit, and it is 0 from the next cycle on.
- R8: A write strobe that arrives while `busy` is 1 is ignored: the ongoing sequence is unchanged and no extra frame follows.
- R9: While `busy` is 1, `txd` changes only at clock edges where `bit_tick` is 1.
- R10: The command is not latched. A write that follows a header write uses only its own command code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_mode | input | 1 | 1 enables the header commands |
| cmd | input | 2 | Command code sampled with the write strobe |
| wr_stb | input | 1 | One-cycle data write strobe |
| wr_data | input | 8 | Written byte (data or identifier) |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| txd | output | 1 | Serial line, 1 is recessive |
| busy | output | 1 | A sequence is in progress |

## Verification
The bench walks each command code with host mode both on and off, including the unused code 3. A design that did not fold these cases back to plain transmission would emit a spurious break, and that break would show up in the captured bit stream.

A write injected in the middle of a break is checked against the line afterwards. A design that accepted it would append a start bit after the header.

Two writes are issued back to back: a header write followed by a plain write. This exposes a command that was wrongly latched, because the second write would then produce a second header.

Line changes between ticks are also counted. A sequencer that advanced without a tick would shorten bits and fail that count.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BREAK,
        ST_DELIM,
        ST_SYNC,
        ST_IDENT,
        ST_DATA
    } seq_state_t;

    typedef enum logic [1:0] {
        CMD_PLAIN = 2'd0,
        CMD_BREAK = 2'd1,
        CMD_AUTO  = 2'd2,
        CMD_RSVD  = 2'd3
    } hdr_cmd_t;

endpackage

// File: rtl/lin_phase_cnt.sv
module lin_phase_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] last_idx,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = en && (cnt == last_idx);

endmodule

// File: rtl/lin_frame_ser.sv
module lin_frame_ser #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] load_data,
    input  logic                 shift,
    output logic                 ser_out,
    output logic                 last
);

    localparam int FRAME_BITS = DATA_BITS + 2;
    localparam int FC_W       = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] shreg;
    logic [FC_W-1:0]       fcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '1;
            fcnt  <= '0;
        end else if (load) begin
            shreg <= {1'b1, load_data, 1'b0};
            fcnt  <= '0;
        end else if (shift) begin
            shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
            fcnt  <= fcnt + 1'b1;
        end
    end

    assign ser_out = shreg[0];
    assign last    = shift && (fcnt == FC_W'(FRAME_BITS - 1));

endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
    import lin_hdr_pkg::*;
#(
    parameter int BREAK_BITS = 13,
    parameter int DELIM_BITS = 1,
    parameter int DATA_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_mode,
    input  logic [1:0]           cmd,
    input  logic                 wr_stb,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 bit_tick,
    output logic                 txd,
    output logic                 busy
);

    localparam int PH_MAX = (BREAK_BITS > DELIM_BITS) ? BREAK_BITS : DELIM_BITS;
    localparam int PH_W   = $clog2(PH_MAX + 1);

    function automatic logic [DATA_BITS-1:0] alt_pattern();
        logic [DATA_BITS-1:0] p;
        for (int i = 0; i < DATA_BITS; i++) begin
            p[i] = (i % 2 == 0);
        end
        return p;
    endfunction

    localparam logic [DATA_BITS-1:0] SYNC_PAT = alt_pattern();

    seq_state_t           state, nxt;
    hdr_cmd_t             eff_cmd;
    logic                 accept;
    logic                 auto_r;
    logic [DATA_BITS-1:0] id_r;
    logic                 ph_clr, ph_en, ph_done;
    logic [PH_W-1:0]      ph_last;
    logic                 ser_load, ser_shift, ser_bit, ser_last;
    logic [DATA_BITS-1:0] ser_byte;

    // Resolve the command actually used for this write
    always_comb begin
        eff_cmd = CMD_PLAIN;
        if (host_mode && (hdr_cmd_t'(cmd) == CMD_BREAK)) eff_cmd = CMD_BREAK;
        if (host_mode && (hdr_cmd_t'(cmd) == CMD_AUTO))  eff_cmd = CMD_AUTO;
    end

    assign accept = wr_stb && (state == ST_IDLE);

    // Break and delimiter timing
    assign ph_en   = bit_tick && ((state == ST_BREAK) || (state == ST_DELIM));
    assign ph_clr  = accept || ph_done;
    assign ph_last = (state == ST_BREAK) ? PH_W'(BREAK_BITS - 1) : PH_W'(DELIM_BITS - 1);

    lin_phase_cnt #(
        .CNT_W(PH_W)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ph_clr),
        .en       (ph_en),
        .last_idx (ph_last),
        .done     (ph_done)
    );

    // Shared character shifter
    assign ser_shift = bit_tick &&
                       ((state == ST_SYNC) || (state == ST_IDENT) || (state == ST_DATA));

    lin_frame_ser #(
        .DATA_BITS(DATA_BITS)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ser_load),
        .load_data (ser_byte),
        .shift     (ser_shift),
        .ser_out   (ser_bit),
        .last      (ser_last)
    );

    // Per-write context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_r <= 1'b0;
            id_r   <= '0;
        end else if (accept) begin
            auto_r <= (eff_cmd == CMD_AUTO);
            id_r   <= wr_data;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state and shifter loading
    always_comb begin
        nxt      = state;
        ser_load = 1'b0;
        ser_byte = wr_data;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (eff_cmd == CMD_PLAIN) begin
                        nxt      = ST_DATA;
                        ser_load = 1'b1;
                        ser_byte = wr_data;
                    end else begin
                        nxt = ST_BREAK;
                    end
                end
            end
            ST_BREAK: begin
                if (ph_done) nxt = ST_DELIM;
            end
            ST_DELIM: begin
                if (ph_done) begin
                    if (auto_r) begin
                        nxt      = ST_SYNC;
                        ser_load = 1'b1;
                        ser_byte = SYNC_PAT;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_SYNC: begin
                if (ser_last) begin
                    nxt      = ST_IDENT;
                    ser_load = 1'b1;
                    ser_byte = id_r;
                end
            end
            ST_IDENT: begin
                if (ser_last) nxt = ST_IDLE;
            end
            ST_DATA: begin
                if (ser_last) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy = (state != ST_IDLE);
        unique case (state)
            ST_IDLE:  txd = 1'b1;
            ST_BREAK: txd = 1'b0;
            ST_DELIM: txd = 1'b1;
            default:  txd = ser_bit;
        endcase
    end

endmodule

// File: rtl/lin_hdr_seq_chk.sv
module lin_hdr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_mode,
    input logic [1:0] cmd,
    input logic       wr_stb,
    input logic       bit_tick,
    input logic       txd,
    input logic       busy
);

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R3
    hdr_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_stb && !busy && host_mode && (cmd == 2'd1 || cmd == 2'd2)) |-> (busy && !txd));

    // R2
    plain_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_stb && !busy && !(host_mode && (cmd == 2'd1 || cmd == 2'd2))) |-> (busy && !txd));

    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_stb));

    // R7
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(bit_tick));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_stb && !bit_tick) |=> busy);

    // R9
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !$past(bit_tick)) |-> $stable(txd));

endmodule

bind lin_hdr_seq lin_hdr_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_mode (host_mode),
    .cmd       (cmd),
    .wr_stb    (wr_stb),
    .bit_tick  (bit_tick),
    .txd       (txd),
    .busy      (busy)
);

// File: tb/lin_hdr_seq_test.sv
module lin_hdr_seq_test;

    localparam int TICK_DIV = 4;
    localparam int NVEC     = 7;
    // {host_mode, cmd[1:0], data[7:0]}
    localparam logic [10:0] VECS [NVEC] = '{
        {1'b1, 2'd2, 8'h3C},
        {1'b1, 2'd1, 8'hA5},
        {1'b1, 2'd0, 8'h96},
        {1'b0, 2'd2, 8'h5A},
        {1'b0, 2'd1, 8'h0F},
        {1'b1, 2'd3, 8'hC3},
        {1'b1, 2'd2, 8'h80}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_mode = 1'b0;
    logic [1:0] cmd = 2'd0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       bit_tick = 1'b0;
    logic       txd, busy;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] exp_bits, got_bits;
    int exp_len;
    int glitches;

    always #4 clk = ~clk;

    lin_hdr_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_mode (host_mode),
        .cmd       (cmd),
        .wr_stb    (wr_stb),
        .bit_tick  (bit_tick),
        .wr_data   (wr_data),
        .txd       (txd),
        .busy      (busy)
    );

    initial begin
        @(negedge clk);
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
        end
    end

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic push_frame(input logic [7:0] b);
        exp_bits[exp_len] = 1'b0;
        exp_len++;
        for (int i = 0; i < 8; i++) begin
            exp_bits[exp_len] = b[i];
            exp_len++;
        end
        exp_bits[exp_len] = 1'b1;
        exp_len++;
    endtask

    task automatic build_exp(input logic hm, input logic [1:0] c, input logic [7:0] d);
        exp_bits = '0;
        exp_len  = 0;
        if (hm && (c == 2'd1 || c == 2'd2)) begin
            for (int i = 0; i < 13; i++) begin
                exp_bits[exp_len] = 1'b0;
                exp_len++;
            end
            exp_bits[exp_len] = 1'b1;
            exp_len++;
            if (c == 2'd2) begin
                push_frame(8'h55);
                push_frame(d);
            end
        end else begin
            push_frame(d);
        end
    endtask

    function automatic string tag_of(input logic hm, input logic [1:0] c);
        if (hm && c == 2'd2) return "R4";
        if (hm && c == 2'd1) return "R3";
        if (!hm && c != 2'd0) return "R5";
        if (c == 2'd3) return "R6";
        return "R2";
    endfunction

    // Issue a write; returns at the negedge after the accepting edge
    task automatic send(input logic hm, input logic [1:0] c, input logic [7:0] d);
        @(negedge clk);
        host_mode = hm;
        cmd       = c;
        wr_data   = d;
        wr_stb    = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        cmd    = 2'd0;
    endtask

    // Collect n bits, one per tick; optionally inject a write at sample index inj
    task automatic capture(input int n, input int inj);
        int   idx = 0;
        logic last_tick = 1'b0;
        logic last_txd = 1'b1;
        got_bits = '0;
        glitches = 0;
        while (idx < n) begin
            #3;
            if (idx > 0 && !last_tick && txd !== last_txd) glitches++;
            last_tick = bit_tick;
            last_txd  = txd;
            if (bit_tick) begin
                got_bits[idx] = txd;
                idx++;
                if (idx == inj) begin
                    @(negedge clk);
                    cmd     = 2'd0;
                    wr_data = 8'h00;
                    wr_stb  = 1'b1;
                    #3;
                    last_tick = bit_tick;
                    last_txd  = txd;
                    if (bit_tick) begin
                        got_bits[idx] = txd;
                        idx++;
                    end
                    @(negedge clk);
                    wr_stb = 1'b0;
                    continue;
                end
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #3;
        // R1 reset state
        check("R1", {62'd0, txd, busy}, {62'd0, 1'b1, 1'b0});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            build_exp(VECS[v][10], VECS[v][9:8], VECS[v][7:0]);
            send(VECS[v][10], VECS[v][9:8], VECS[v][7:0]);
            #1;
            check("R7", {63'd0, busy}, 64'd1);
            capture(exp_len, -1);
            check(tag_of(VECS[v][10], VECS[v][9:8]), got_bits, exp_bits);
            check("R9", 64'(glitches), 64'd0);
            #1;
            check("R7", {62'd0, txd, busy}, {62'd0, 1'b1, 1'b0});
            repeat (3) @(negedge clk);
        end

        // R8: write in the middle of a break is ignored
        build_exp(1'b1, 2'd2, 8'h3C);
        send(1'b1, 2'd2, 8'h3C);
        capture(exp_len, 5);
        check("R8", got_bits, exp_bits);
        begin
            int lows = 0;
            for (int k = 0; k < 12 * TICK_DIV; k++) begin
                #3;
                if (txd !== 1'b1 || busy !== 1'b0) lows++;
                @(negedge clk);
            end
            check("R8", 64'(lows), 64'd0);
        end

        // R10: header write followed at once by a plain write
        build_exp(1'b1, 2'd1, 8'h11);
        send(1'b1, 2'd1, 8'h11);
        capture(exp_len, -1);
        check("R10", got_bits, exp_bits);
        build_exp(1'b1, 2'd0, 8'h6E);
        send(1'b1, 2'd0, 8'h6E);
        capture(exp_len, -1);
        check("R10", got_bits, exp_bits);

        repeat (4) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule